// File: doc/BRIEF.md
# Multiplexed Shared-Bus Master

This block lets a local client reach memory or I/O targets over a shared parallel bus. The bus carries a 32-bit address on a 16-bit combined address/data path. The client presents one request at a time: a direction, a space (memory or I/O), an address and, for writes, a 16-bit data word.

The master first raises its bus request and waits for the arbiter's grant. It then sends the address as two halves on consecutive cycles, upper half first. Next it raises one of four command strobes and holds it until the target acknowledges. For a write, the data word stays on the shared lines while the strobe is active. For a read, the master stops driving the lines and captures the target's word in the acknowledge cycle.

In the cycle after the acknowledge, the master gives the bus up and pulses a completion flag. If no acknowledge arrives within a parameterised number of strobe cycles, the transfer is abandoned. It then completes with an error flag instead.

Top module: `mxbus_master`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `bus_req`, `ad_oe`, all four strobes, `rsp_done` and `rsp_err` are low. A reset asserted in the middle of a transfer forces all of them low.
- R2: A request sampled with `req_valid` high while the master is idle raises `bus_req` in the next cycle. While `bus_gnt` stays low, `bus_req` stays high, `ad_oe` stays low and no strobe is raised, for any number of cycles.
- R3: The cycle after `bus_gnt` is sampled high, `ad_out` carries address bits 31..16 with `ad_oe` high. The cycle after that, it carries bits 15..0 with `ad_oe` high.
- R4: From the cycle after the lower address half, exactly one strobe is high until the transfer ends. The strobe is selected by the code {`req_io`,`req_write`}: 0 gives `mem_rd`, 1 gives `mem_wr`, 2 gives `io_rd` and 3 gives `io_wr`.
- R5: While a write strobe is high, `ad_out` carries the request's write data with `ad_oe` high. While a read strobe is high, `ad_oe` is low.
- R6: In the cycle after `xfer_ack` is sampled high during a strobe, the following hold:
  - `bus_req`, `ad_oe` and all strobes are low.
  - `rsp_done` is high for exactly one cycle, and `rsp_err` is low.
  - For a read, `rsp_rdata` equals the `ad_in` value sampled with the acknowledge.
- R7: `ad_oe` is never high unless `bus_req` is high.
- R8: If no acknowledge is sampled in the first TIMEOUT cycles of a strobe, the transfer ends after that many cycles. The strobe is never high for more than TIMEOUT consecutive cycles. In the next cycle the bus is released as in R6, and `rsp_done` and `rsp_err` are both high.
- R9: Requests presented while a transfer is in progress are ignored. The address halves and write data on the bus are those of the request accepted when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was a timeout |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| ad_out | output | DATA_W | Value for shared address/data lines |
| ad_oe | output | 1 | Drive enable for shared lines |
| ad_in | input | DATA_W | Value seen on shared lines |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| xfer_ack | input | 1 | Transfer acknowledge from target |

## Verification
The bench builds the master with TIMEOUT set to 4 and the 32/16 widths kept. With that timeout, every acknowledge position from the first strobe cycle to one past the limit can be swept. This includes an acknowledge in the last allowed cycle and a true timeout. The sweep crosses all four command codes with grant delays of zero to two cycles, using arithmetically derived addresses and data. Garbage requests are held on the local port and stale values on `ad_in` during every non-acknowledge cycle, so that latching in the wrong cycle shows up.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_XFER
    } mx_state_e;

    // code = {io, write}
    typedef enum logic [1:0] {
        CMD_MEM_RD = 2'd0,
        CMD_MEM_WR = 2'd1,
        CMD_IO_RD  = 2'd2,
        CMD_IO_WR  = 2'd3
    } mx_cmd_e;

    localparam int unsigned NUM_STROBES = 4;

    function automatic mx_cmd_e mk_cmd(input logic io, input logic wr);
        return mx_cmd_e'({io, wr});
    endfunction

    function automatic logic cmd_is_write(input mx_cmd_e c);
        return c[0];
    endfunction

endpackage

// File: rtl/mxbus_wdog.sv
module mxbus_wdog #(
    parameter int unsigned LIMIT = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && (cnt_q == CW'(LIMIT - 1));
        if (!run) begin
            cnt_d = '0;
        end else if (expire) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
    import mxbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_gnt,
    input  logic              xfer_ack,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              tmo_expire,
    output mx_state_e         state,
    output mx_cmd_e           cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        mx_state_e         st;
        mx_cmd_e           cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_ARB;
                    r_d.cmd   = mk_cmd(req_io, req_write);
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                end
            end
            ST_ARB: begin
                if (bus_gnt) begin
                    r_d.st = ST_ADR_HI;
                end
            end
            ST_ADR_HI: r_d.st = ST_ADR_LO;
            ST_ADR_LO: r_d.st = ST_XFER;
            ST_XFER: begin
                if (xfer_ack) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (!cmd_is_write(r_q.cmd)) begin
                        r_d.rdata = ad_in;
                    end
                end else if (tmo_expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cmd   <= CMD_MEM_RD;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.rdata <= '0;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.st;
    assign cmd       = r_q.cmd;
    assign addr      = r_q.addr;
    assign wdata     = r_q.wdata;
    assign rsp_done  = r_q.done;
    assign rsp_err   = r_q.err;
    assign rsp_rdata = r_q.rdata;

endmodule

// File: rtl/mxbus_drive.sv
module mxbus_drive
    import mxbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 16
) (
    input  mx_state_e                state,
    input  mx_cmd_e                  cmd,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic                     bus_req,
    output logic                     ad_oe,
    output logic [DATA_W-1:0]        ad_out,
    output logic [NUM_STROBES-1:0]   strobe
);
    localparam int unsigned HI_LSB = ADDR_W - DATA_W;

    logic in_xfer;

    always_comb begin
        in_xfer = (state == ST_XFER);
        bus_req = (state != ST_IDLE);
        ad_oe   = 1'b0;
        ad_out  = '0;
        case (state)
            ST_ADR_HI: begin
                ad_oe  = 1'b1;
                ad_out = addr[ADDR_W-1:HI_LSB];
            end
            ST_ADR_LO: begin
                ad_oe  = 1'b1;
                ad_out = addr[DATA_W-1:0];
            end
            ST_XFER: begin
                ad_oe  = cmd_is_write(cmd);
                ad_out = cmd_is_write(cmd) ? wdata : '0;
            end
            default: begin
                ad_oe  = 1'b0;
                ad_out = '0;
            end
        endcase
    end

    for (genvar k = 0; k < NUM_STROBES; k++) begin : g_strobe
        assign strobe[k] = in_xfer && (cmd == mx_cmd_e'(k));
    end

endmodule

// File: rtl/mxbus_master.sv
module mxbus_master
    import mxbus_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned TIMEOUT = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    input  logic              xfer_ack
);

    mx_state_e               state;
    mx_cmd_e                 cmd;
    logic [ADDR_W-1:0]       addr;
    logic [DATA_W-1:0]       wdata;
    logic                    tmo_expire;
    logic [NUM_STROBES-1:0]  strobe;

    mxbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_io     (req_io),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_gnt    (bus_gnt),
        .xfer_ack   (xfer_ack),
        .ad_in      (ad_in),
        .tmo_expire (tmo_expire),
        .state      (state),
        .cmd        (cmd),
        .addr       (addr),
        .wdata      (wdata),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err),
        .rsp_rdata  (rsp_rdata)
    );

    mxbus_wdog #(.LIMIT(TIMEOUT)) i_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_XFER),
        .expire (tmo_expire)
    );

    mxbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_drive (
        .state   (state),
        .cmd     (cmd),
        .addr    (addr),
        .wdata   (wdata),
        .bus_req (bus_req),
        .ad_oe   (ad_oe),
        .ad_out  (ad_out),
        .strobe  (strobe)
    );

    assign mem_rd = strobe[CMD_MEM_RD];
    assign mem_wr = strobe[CMD_MEM_WR];
    assign io_rd  = strobe[CMD_IO_RD];
    assign io_wr  = strobe[CMD_IO_WR];

endmodule

// File: rtl/mxbus_master_chk.sv
module mxbus_master_chk #(
    parameter int unsigned TIMEOUT = 255
) (
    input logic clk,
    input logic rst_n,
    input logic rsp_done,
    input logic rsp_err,
    input logic bus_req,
    input logic bus_gnt,
    input logic ad_oe,
    input logic mem_rd,
    input logic mem_wr,
    input logic io_rd,
    input logic io_wr,
    input logic xfer_ack
);
    localparam int unsigned CW = $clog2(TIMEOUT + 2);

    logic [3:0]    strb;
    logic          any_strb;
    logic [CW-1:0] run_q;

    assign strb     = {io_wr, io_rd, mem_wr, mem_rd};
    assign any_strb = |strb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= any_strb ? run_q + CW'(1) : '0;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb)); // R4

    AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        any_strb |-> bus_req); // R2

    AST_DRIVE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> bus_req); // R7

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || io_rd) |-> !ad_oe); // R5

    AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(bus_gnt)); // R3

    AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strb && xfer_ack) |=> (!bus_req && !ad_oe && strb == 4'b0 && rsp_done && !rsp_err)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R6

    AST_STROBE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        any_strb |-> (run_q < CW'(TIMEOUT))); // R8

    AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strb && !xfer_ack && run_q == CW'(TIMEOUT - 1)) |=> (rsp_done && rsp_err && !bus_req)); // R8

endmodule

bind mxbus_master mxbus_master_chk #(.TIMEOUT(TIMEOUT)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .ad_oe    (ad_oe),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .xfer_ack (xfer_ack)
);

// File: tb/test_mxbus_master.sv
module test_mxbus_master;
    localparam int AW  = 32;
    localparam int DW  = 16;
    localparam int TMO = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write, req_io;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          bus_req, bus_gnt;
    logic [DW-1:0] ad_out, ad_in;
    logic          ad_oe;
    logic          mem_rd, mem_wr, io_rd, io_wr;
    logic          xfer_ack;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    mxbus_master #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT(TMO)) i_mxbus_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .xfer_ack(xfer_ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [3:0] strobes();
        return {io_wr, io_rd, mem_wr, mem_rd};
    endfunction

    task automatic check_quiet(input string tag);
        check({tag, " bus_req"}, 32'(bus_req), 32'd0);
        check({tag, " ad_oe"},   32'(ad_oe),   32'd0);
        check({tag, " strobes"}, 32'(strobes()), 32'd0);
    endtask

    task automatic do_xfer(input logic wr, input logic io, input logic [31:0] a,
                           input logic [15:0] wd, input int g, input int d,
                           input logic [15:0] rd);
        logic [3:0] exp_strb;
        exp_strb  = 4'b0001 << {io, wr};
        req_valid = 1'b1; req_write = wr; req_io = io;
        req_addr  = a;    req_wdata = wd;
        bus_gnt   = 1'b0; xfer_ack  = 1'b0; ad_in = ~rd;
        step();
        // R9: garbage requests held while busy
        req_addr = ~a; req_wdata = ~wd; req_write = ~wr; req_io = ~io;
        for (int i = 0; i <= g; i++) begin
            check("R2 bus_req while waiting", 32'(bus_req), 32'd1);
            check("R7 no drive before grant", 32'(ad_oe), 32'd0);
            check("R2 no strobe before grant", 32'(strobes()), 32'd0);
            if (i == g) bus_gnt = 1'b1;
            step();
        end
        bus_gnt = 1'b0;
        check("R3 upper half oe", 32'(ad_oe), 32'd1);
        check("R3 R9 upper half", 32'(ad_out), 32'(a[31:16]));
        step();
        check("R3 lower half oe", 32'(ad_oe), 32'd1);
        check("R3 R9 lower half", 32'(ad_out), 32'(a[15:0]));
        step();
        for (int i = 0; i < TMO; i++) begin
            check("R4 strobe select", 32'(strobes()), 32'(exp_strb));
            check("R5 drive during strobe", 32'(ad_oe), 32'(wr));
            if (wr) check("R5 R9 write data", 32'(ad_out), 32'(wd));
            xfer_ack = (i == d);
            ad_in    = (i == d) ? rd : ~rd;
            if (i == d || i == TMO - 1) req_valid = 1'b0;
            step();
            xfer_ack = 1'b0;
            ad_in    = ~rd;
            if (i == d) break;
        end
        if (d < TMO) begin
            check("R6 done after ack", 32'(rsp_done), 32'd1);
            check("R6 no err after ack", 32'(rsp_err), 32'd0);
            check_quiet("R6 release after ack");
            if (!wr) check("R6 read data", 32'(rsp_rdata), 32'(rd));
        end else begin
            check("R8 done on timeout", 32'(rsp_done), 32'd1);
            check("R8 err on timeout", 32'(rsp_err), 32'd1);
            check_quiet("R8 release on timeout");
        end
        step();
        check("R6 done is one pulse", 32'(rsp_done), 32'd0);
        check("R9 idle after completion", 32'(bus_req), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
        req_addr = '0; req_wdata = '0; bus_gnt = 1'b0; xfer_ack = 1'b0; ad_in = '0;
        repeat (3) step();
        check_quiet("R1 in reset");
        check("R1 done in reset", 32'(rsp_done), 32'd0);
        check("R1 err in reset", 32'(rsp_err), 32'd0);
        rst_n = 1'b1;
        step();
        step();
        check_quiet("R1 idle after reset");
        check("R1 done idle", 32'(rsp_done), 32'd0);

        for (int c = 0; c < 4; c++) begin
            for (int g = 0; g < 3; g++) begin
                for (int d = 0; d <= TMO; d++) begin
                    logic [31:0] idx, a;
                    logic [15:0] wd, rd;
                    idx = 32'((c * 3 + g) * (TMO + 1) + d + 1);
                    a   = idx * 32'h9E37_79B9 + 32'h0123_4567;
                    wd  = a[23:8] ^ 16'h5A5A;
                    rd  = ~a[15:0] + idx[15:0];
                    do_xfer(c[0], c[1], a, wd, g, d, rd);
                end
            end
        end

        // R1: reset in the middle of a transfer
        req_valid = 1'b1; req_write = 1'b1; req_io = 1'b1;
        req_addr = 32'hDEAD_BEEF; req_wdata = 16'h1234;
        step();
        req_valid = 1'b0; bus_gnt = 1'b1;
        step();
        bus_gnt = 1'b0;
        check("R3 upper half before reset", 32'(ad_out), 32'h0000_DEAD);
        rst_n = 1'b0;
        #1;
        check_quiet("R1 mid-transfer reset");
        step();
        rst_n = 1'b1;
        step();
        check_quiet("R1 idle after mid reset");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule